// File: doc/BRIEF.md
# Banked GPIO Pin Controller

This block controls up to 128 general-purpose pins, grouped into banks of 32. Each bank has a direction word and an output latch. Software never writes the latch directly: one register sets latch bits and another clears them, so two agents can change different pins without a read-modify-write. Each bank also holds two alternate-function words. These are plain storage here, because pad multiplexing lies outside the block.

Registers are reached over a simple single-cycle request bus with a 9-bit word index, so the byte offset is the index times four. A read returns its data one cycle after the request. A level read merges two sources: output pins report their latch value and input pins report the sampled pad input. The pad side has three buses. `pin_in` carries sampled levels. `pad_out` drives each pin's latch value, and it is forced to 0 on input pins. `pad_oe` marks the pins configured as outputs.

The register map is irregular. In each group, banks 0 to 2 sit at consecutive words and bank 3 sits 0x100 bytes above bank 0. The edge-detect and interrupt offsets are not implemented in this block, and they behave as reserved holes.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset, every direction, latch, last-set and alternate-function word is 0. So `pad_oe` and `pad_out` are 0, and a level read returns `pin_in`.
- R2: Byte offsets decode as follows, with bank b at base+4*b for b<3 and at base+0x100 for b=3. Level has base 0x000, direction 0x00C, set 0x018 and clear 0x024. The alternate-function low word of bank b is at 0x054+8*b and the high word at 0x058+8*b. Every other offset below 0x200 is reserved, including the edge-related groups at 0x030, 0x03C and 0x048 and their bank-3 copies.
- R3: Writing the set register of a bank ORs the written data into that bank's latch.
- R4: Writing the clear register of a bank ANDs that bank's latch with the inverse of the written data.
- R5: Reading a set register returns the last value written to it. Reading a clear register returns the constant 0x00007A69.
- R6: A level read returns the latch bit where the direction bit is 1 and the `pin_in` bit where it is 0.
- R7: A request with a word index of 0x80 or above (byte offset 0x200 or higher) changes no state and raises no error. If it is a read, it returns 0.
- R8: `pad_oe` equals the direction word. `pad_out` equals latch AND direction.
- R9: A request to a reserved offset below 0x200 changes no state. A read there returns 0. Either kind of request raises `rsp_err` for exactly the one cycle after the request.
- R10: A write takes effect at the clock edge that accepts it. Read data and `rsp_valid` appear in the cycle after the read request, and `rsp_valid` stays low after writes and idle cycles.
- R11: The two alternate-function words of each bank read back what was last written to them.
- R12: A write to a level register is ignored and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 9 | Word index (byte offset / 4) |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | One-cycle pulse after a reserved in-range access |
| pin_in | input | 128 | Sampled pad input levels |
| pad_out | output | 128 | Pad output values, 0 on input pins |
| pad_oe | output | 128 | Pad output enables (direction) |

## Verification
The bench sweeps every in-range word index, first reading and then writing a distinct pattern to each. It then reads the whole map back against an arithmetic model. This catches a decoder that folds bank 3 into the consecutive slots, misses a reserved hole, or swaps the low and high alternate-function words. A latch that takes set data as a plain store would lose earlier bits. Clear data that is not inverted would wipe the wrong pins. A level read that ignores direction would return latch bits on input pins. Each of these shows up in the set/clear and merge checks. Aliasing of indices at 0x80 and above onto the low map would change the direction word, and a write to a level register that raised an error or stored data would show in later reads and pad values.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
   localparam int unsigned WORD_W    = 32;
   localparam int unsigned MAX_BANKS = 4;
   localparam int unsigned IDX_W     = 9;

   typedef enum logic [2:0] {
      K_NONE, K_LEVEL, K_DIR, K_SET, K_CLR, K_AFLO, K_AFHI
   } reg_kind_e;

   typedef struct packed {
      logic      in_range;
      reg_kind_e kind;
      logic [1:0] bank;
   } reg_sel_t;

   // groups of three words in the low page; 4..6 are edge-related holes
   function automatic reg_kind_e grp_kind(input logic [2:0] g);
      case (g)
         3'd0:    return K_LEVEL;
         3'd1:    return K_DIR;
         3'd2:    return K_SET;
         3'd3:    return K_CLR;
         default: return K_NONE;
      endcase
   endfunction
endpackage

// File: rtl/gpio_ofs_decode.sv
module gpio_ofs_decode
   import gpio_bank_pkg::*;
#(
   parameter int unsigned BANKS = 4
) (
   input  logic [IDX_W-1:0] word_idx,
   output reg_sel_t         sel
);
   logic [5:0] idx;
   logic [2:0] grp;
   logic [1:0] sub;
   logic [4:0] afo;

   always_comb begin
      idx = word_idx[5:0];
      grp = 3'(idx / 6'd3);
      sub = 2'(idx % 6'd3);
      afo = 5'(idx - 6'd21);
      sel.in_range = (word_idx[8:7] == 2'b00);
      sel.kind     = K_NONE;
      sel.bank     = 2'd0;
      if (!word_idx[6]) begin
         if (idx < 6'd21) begin
            sel.kind = grp_kind(grp);
            sel.bank = sub;
         end else if (idx < 6'd29) begin
            sel.kind = afo[0] ? K_AFHI : K_AFLO;
            sel.bank = afo[2:1];
         end
      end else if (idx < 6'd21 && sub == 2'd0) begin
         sel.kind = grp_kind(grp);
         sel.bank = 2'd3;
      end
      if (!sel.in_range || int'(sel.bank) >= int'(BANKS))
         sel.kind = K_NONE;
   end
endmodule

// File: rtl/gpio_pin_bank.sv
module gpio_pin_bank #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_dir,
   input  logic         wr_set,
   input  logic         wr_clr,
   input  logic         wr_aflo,
   input  logic         wr_afhi,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] pin_in,
   output logic [W-1:0] dir_q,
   output logic [W-1:0] lat_q,
   output logic [W-1:0] setlast_q,
   output logic [W-1:0] aflo_q,
   output logic [W-1:0] afhi_q,
   output logic [W-1:0] level_o,
   output logic [W-1:0] pad_out,
   output logic [W-1:0] pad_oe
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q     <= '0;
         lat_q     <= '0;
         setlast_q <= '0;
         aflo_q    <= '0;
         afhi_q    <= '0;
      end else begin
         if (wr_dir)  dir_q  <= wdata;
         if (wr_aflo) aflo_q <= wdata;
         if (wr_afhi) afhi_q <= wdata;
         if (wr_set) begin
            lat_q     <= lat_q | wdata;
            setlast_q <= wdata;
         end else if (wr_clr) begin
            lat_q <= lat_q & ~wdata;
         end
      end
   end

   assign level_o = (lat_q & dir_q) | (pin_in & ~dir_q);
   assign pad_out = lat_q & dir_q;
   assign pad_oe  = dir_q;

   // R3
   set_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_set |=> lat_q == ($past(lat_q) | $past(wdata)));
   // R4
   clr_andn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_clr && !wr_set |=> lat_q == ($past(lat_q) & ~$past(wdata)));
   // R10
   latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_set || wr_clr) |=> $stable(lat_q));
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
   import gpio_bank_pkg::*;
#(
   parameter int unsigned BANKS        = 4,
   parameter logic [31:0] CLR_READ_VAL = 32'h0000_7A69,
   localparam int unsigned PINS        = BANKS * WORD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [IDX_W-1:0]  req_word,
   input  logic [WORD_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [WORD_W-1:0] rsp_rdata,
   output logic              rsp_err,
   input  logic [PINS-1:0]   pin_in,
   output logic [PINS-1:0]   pad_out,
   output logic [PINS-1:0]   pad_oe
);
   if (BANKS < 1 || BANKS > MAX_BANKS) begin : g_bad_banks
      $error("gpio_bank_ctrl: BANKS must be 1..4");
   end

   reg_sel_t sel;
   gpio_ofs_decode #(.BANKS(BANKS)) u_dec (.word_idx(req_word), .sel(sel));

   logic acc, wr_hit, rd_req;
   assign acc    = req_valid & sel.in_range;
   assign wr_hit = acc & req_write;
   assign rd_req = req_valid & ~req_write;

   logic [WORD_W-1:0] dir_a [MAX_BANKS];
   logic [WORD_W-1:0] lat_a [MAX_BANKS];
   logic [WORD_W-1:0] set_a [MAX_BANKS];
   logic [WORD_W-1:0] alo_a [MAX_BANKS];
   logic [WORD_W-1:0] ahi_a [MAX_BANKS];
   logic [WORD_W-1:0] lvl_a [MAX_BANKS];

   for (genvar b = 0; b < MAX_BANKS; b++) begin : g_bank
      if (b < BANKS) begin : g_live
         logic hit;
         assign hit = wr_hit && (sel.bank == 2'(b));
         gpio_pin_bank #(.W(WORD_W)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_dir   (hit && sel.kind == K_DIR),
            .wr_set   (hit && sel.kind == K_SET),
            .wr_clr   (hit && sel.kind == K_CLR),
            .wr_aflo  (hit && sel.kind == K_AFLO),
            .wr_afhi  (hit && sel.kind == K_AFHI),
            .wdata    (req_wdata),
            .pin_in   (pin_in[b*WORD_W +: WORD_W]),
            .dir_q    (dir_a[b]),
            .lat_q    (lat_a[b]),
            .setlast_q(set_a[b]),
            .aflo_q   (alo_a[b]),
            .afhi_q   (ahi_a[b]),
            .level_o  (lvl_a[b]),
            .pad_out  (pad_out[b*WORD_W +: WORD_W]),
            .pad_oe   (pad_oe[b*WORD_W +: WORD_W])
         );
      end else begin : g_absent
         assign dir_a[b] = '0;
         assign lat_a[b] = '0;
         assign set_a[b] = '0;
         assign alo_a[b] = '0;
         assign ahi_a[b] = '0;
         assign lvl_a[b] = '0;
      end
   end

   logic [WORD_W-1:0] rd_val, dir_sel, lat_sel;
   assign dir_sel = dir_a[sel.bank];
   assign lat_sel = lat_a[sel.bank];

   always_comb begin
      case (sel.kind)
         K_LEVEL: rd_val = lvl_a[sel.bank];
         K_DIR:   rd_val = dir_a[sel.bank];
         K_SET:   rd_val = set_a[sel.bank];
         K_CLR:   rd_val = CLR_READ_VAL;
         K_AFLO:  rd_val = alo_a[sel.bank];
         K_AFHI:  rd_val = ahi_a[sel.bank];
         default: rd_val = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
         rsp_err   <= 1'b0;
      end else begin
         rsp_valid <= rd_req;
         rsp_err   <= acc && sel.kind == K_NONE;
         if (rd_req) rsp_rdata <= rd_val;
      end
   end

   // R7
   far_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req && !sel.in_range |=> rsp_rdata == '0 && !rsp_err);
   // R9
   err_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> $past(req_valid));
   // R10
   rsp_valid_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid == $past(rd_req));
   // R6
   level_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req && sel.kind == K_LEVEL |=>
         ((rsp_rdata ^ $past(lat_sel)) & $past(dir_sel)) == '0);
endmodule

// File: tb/test_gpio_bank_ctrl.sv
module test_gpio_bank_ctrl;
   localparam int BANKS = 4;
   localparam int PINS  = 128;
   localparam logic [31:0] CLR_CONST = 32'h0000_7A69;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic             req_valid = 1'b0, req_write = 1'b0;
   logic [8:0]       req_word = '0;
   logic [31:0]      req_wdata = '0;
   logic             rsp_valid, rsp_err;
   logic [31:0]      rsp_rdata;
   logic [PINS-1:0]  pin_in = '0;
   logic [PINS-1:0]  pad_out, pad_oe;

   gpio_bank_ctrl #(.BANKS(BANKS)) i_gpio_bank_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_word(req_word), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
      .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .pin_in(pin_in),
      .pad_out(pad_out), .pad_oe(pad_oe));

   int checks = 0, failures = 0;
   bit done = 1'b0;
   logic [31:0] m_dir[4], m_lat[4], m_set[4], m_alo[4], m_ahi[4];

   task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // kinds: 0 reserved, 1 level, 2 dir, 3 set, 4 clear, 5 af-low, 6 af-high, 7 out of range
   function automatic int decode(input int w, output int bank);
      int off = w * 4;
      int base [1:4] = '{0, 'h0C, 'h18, 'h24};
      bank = 0;
      if (off >= 'h200) return 7;
      for (int k = 1; k <= 4; k++)
         for (int b = 0; b < 4; b++)
            if (off == ((b < 3) ? base[k] + 4*b : base[k] + 'h100)) begin
               bank = b; return k;
            end
      for (int b = 0; b < 4; b++) begin
         if (off == 'h54 + 8*b) begin bank = b; return 5; end
         if (off == 'h58 + 8*b) begin bank = b; return 6; end
      end
      return 0;
   endfunction

   function automatic logic [31:0] model_read(input int w);
      int b;
      int k = decode(w, b);
      case (k)
         1: return (m_lat[b] & m_dir[b]) | (pin_in[b*32 +: 32] & ~m_dir[b]);
         2: return m_dir[b];
         3: return m_set[b];
         4: return CLR_CONST;
         5: return m_alo[b];
         6: return m_ahi[b];
         default: return 32'h0;
      endcase
   endfunction

   task automatic model_write(input int w, input logic [31:0] d);
      int b;
      int k = decode(w, b);
      case (k)
         2: m_dir[b] = d;
         3: begin m_lat[b] = m_lat[b] | d; m_set[b] = d; end
         4: m_lat[b] = m_lat[b] & ~d;
         5: m_alo[b] = d;
         6: m_ahi[b] = d;
         default: ;
      endcase
   endtask

   function automatic logic exp_err(input int w);
      int b;
      return decode(w, b) == 0;
   endfunction

   function automatic logic [127:0] pads_exp(input bit oe);
      logic [127:0] v;
      for (int b = 0; b < 4; b++) v[b*32 +: 32] = oe ? m_dir[b] : (m_lat[b] & m_dir[b]);
      return v;
   endfunction

   // called at a negedge; returns at the following negedge
   task automatic access(input bit wr, input int w, input logic [31:0] d);
      req_valid = 1'b1; req_write = wr; req_word = w[8:0]; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
   endtask

   task automatic rd_chk(input string tag, input int w);
      access(1'b0, w, 32'h0);
      chk(tag, rsp_rdata, model_read(w));
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL R10 watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      for (int b = 0; b < 4; b++) begin
         m_dir[b] = '0; m_lat[b] = '0; m_set[b] = '0; m_alo[b] = '0; m_ahi[b] = '0;
      end
      pin_in = {32'hC3A5_5A3C, 32'h0F0F_1234, 32'hDEAD_BEEF, 32'h8001_7FFE};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      chk("R1 pad_oe", pad_oe, '0);
      chk("R1 pad_out", pad_out, '0);
      chk("R1 rsp_valid idle", rsp_valid, 0);
      access(1'b0, 'h40, 0);
      chk("R1 bank3 level = pin_in", rsp_rdata, pin_in[127:96]);

      // R2 / R9: read sweep over the whole in-range map
      for (int w = 0; w < 128; w++) begin
         access(1'b0, w, 0);
         chk($sformatf("R2 read w=%0h", w), rsp_rdata, model_read(w));
         chk($sformatf("R9 err w=%0h", w), rsp_err, exp_err(w));
         chk("R10 rsp_valid", rsp_valid, 1);
      end
      // R2 / R11 / R12: write sweep, then read back everything
      for (int w = 0; w < 128; w++) begin
         logic [31:0] d = 32'h9E37_79B9 * (w + 1);
         access(1'b1, w, d);
         model_write(w, d);
         chk($sformatf("R9 wr err w=%0h", w), rsp_err, exp_err(w));
         chk("R10 no rsp_valid on write", rsp_valid, 0);
      end
      chk("R8 pad_oe after sweep", pad_oe, pads_exp(1));
      chk("R8 pad_out after sweep", pad_out, pads_exp(0));
      for (int w = 0; w < 128; w++) rd_chk($sformatf("R2 readback w=%0h", w), w);

      // R3 / R4 / R5 on bank 0
      access(1'b1, 'h03, 32'hFFFF_FFFF); model_write('h03, 32'hFFFF_FFFF);
      access(1'b1, 'h09, 32'hFFFF_FFFF); model_write('h09, 32'hFFFF_FFFF);
      access(1'b1, 'h06, 32'h0000_00F0); model_write('h06, 32'h0000_00F0);
      chk("R10 pad_out same edge", pad_out[31:0], 32'h0000_00F0);
      access(1'b1, 'h06, 32'h0F00_0000); model_write('h06, 32'h0F00_0000);
      access(1'b0, 'h00, 0);
      chk("R3 set ORs", rsp_rdata, 32'h0F00_00F0);
      access(1'b1, 'h09, 32'h0000_0030); model_write('h09, 32'h0000_0030);
      access(1'b0, 'h00, 0);
      chk("R4 clear ANDs inverse", rsp_rdata, 32'h0F00_00C0);
      access(1'b0, 'h06, 0);
      chk("R5 set readback", rsp_rdata, 32'h0F00_0000);
      access(1'b0, 'h49, 0);
      chk("R5 clear readback", rsp_rdata, CLR_CONST);

      // R6: mixed direction on bank 3 and bank 1, new inputs
      pin_in = {32'h1357_9BDF, 32'hFFFF_0000, 32'h2468_ACE0, 32'h0};
      access(1'b1, 'h43, 32'hFFFF_0000); model_write('h43, 32'hFFFF_0000);
      access(1'b1, 'h46, 32'hAAAA_AAAA); model_write('h46, 32'hAAAA_AAAA);
      access(1'b0, 'h40, 0);
      chk("R6 level bank3", rsp_rdata, (m_lat[3] & 32'hFFFF_0000) | 32'h0000_9BDF);
      rd_chk("R6 level bank1", 'h01);
      chk("R8 pad_out", pad_out, pads_exp(0));
      chk("R8 pad_oe", pad_oe, pads_exp(1));

      // R7: beyond 0x200 ignored
      access(1'b1, 'h83, 32'h0);
      chk("R7 no err write", rsp_err, 0);
      access(1'b1, 'h1C6, 32'hFFFF_FFFF);
      access(1'b0, 'h80, 0);
      chk("R7 read zero", rsp_rdata, 0);
      chk("R7 no err read", rsp_err, 0);
      rd_chk("R7 dir bank0 untouched", 'h03);
      chk("R7 pads untouched", pad_out, pads_exp(0));

      // R9: reserved read/write, one-cycle error pulse
      access(1'b0, 'h0C, 0);
      chk("R9 reserved read zero", rsp_rdata, 0);
      chk("R9 err pulse", rsp_err, 1);
      @(negedge clk);
      chk("R9 err one cycle", rsp_err, 0);
      chk("R10 rsp_valid low idle", rsp_valid, 0);
      access(1'b1, 'h12, 32'hFFFF_FFFF);
      chk("R9 reserved write err", rsp_err, 1);
      chk("R9 reserved write no pad change", pad_out, pads_exp(0));

      // R11: bank 3 alternate-function words
      access(1'b1, 'h1B, 32'h1234_5678); model_write('h1B, 32'h1234_5678);
      access(1'b1, 'h1C, 32'h9ABC_DEF0); model_write('h1C, 32'h9ABC_DEF0);
      access(1'b0, 'h1B, 0);
      chk("R11 af low bank3", rsp_rdata, 32'h1234_5678);
      access(1'b0, 'h1C, 0);
      chk("R11 af high bank3", rsp_rdata, 32'h9ABC_DEF0);

      // R12: writing a level register is ignored
      access(1'b1, 'h02, 32'hFFFF_FFFF);
      chk("R12 no err", rsp_err, 0);
      chk("R12 pads unchanged", pad_out, pads_exp(0));
      rd_chk("R12 level bank2", 'h02);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule